// File: doc/BRIEF.md
# E3 Receive Alarm Monitor

This block watches the receive side of an E3 framer. It samples the recovered dual-rail line data on the line clock and detects loss of signal from runs of zero bits. A zero bit is a clock in which both the positive and the negative rail are low. It merges that result with an external loss-of-signal input and drives a single LOS pin.

It also follows the in-frame status reported by a separate alignment core and turns it into a two-pin framing state. When the core loses alignment, the pins report out-of-frame for a timed interval. If alignment has not returned by the end of that interval, the pins report loss of frame. The nominal interval is 3 ms, set as a count of line clocks.

A small byte-wide register port lets software do three things. It can set the LOS mode. It can read a 16-bit event counter of bad framing alignment bytes; the counter clears when read and saturates. Reading the low byte captures the high byte, so the two reads see one coherent value.

Top module: `e3_rx_alarm_mon`

## Requirements
- R1: The framing pins {lof_out, oof_out} take the code 2'b00 in frame, 2'b01 during the out-of-frame interval and 2'b11 in loss of frame. The code 2'b10 never appears.
- R2: In the in-frame state, a clock edge that samples core_in_frame low moves the pins to 2'b01 at that edge.
- R3: The pins move from 2'b01 to 2'b11 exactly OOF_CLKS edges after entering the out-of-frame state, provided core_in_frame stays low for that whole time.
- R4: An edge that samples core_in_frame high returns the pins to 2'b00 from either alarm state. That edge also restarts the out-of-frame timer, so the next loss of alignment again lasts a full OOF_CLKS edges.
- R5: Mode register bit 5 enables the internal detector. With that bit set, los_out rises at the edge that samples the INT_RUN-th consecutive zero bit, which is 180 by default. One zero fewer leaves los_out low.
- R6: Mode register bit 1 enables the short-run detector. With that bit set, los_out rises at the edge that samples the SHORT_RUN-th consecutive zero bit, which is 32 by default.
- R7: A high ext_los sets los_out at the next edge in every mode. los_out stays high while ext_los is high, even when the rails carry ones.
- R8: With mode bits 5 and 1 both clear, a zero run of any length leaves los_out low.
- R9: los_out stays high through arbitrarily long zero runs, because the run counter saturates and does not wrap. los_out clears at the edge that samples a one on either rail while ext_los is low.
- R10: Each clock with fa_chk_vld high adds one event for fa1_bad and one for fa2_bad. The 16-bit count is read as the low byte at address 0x52 and the high byte at address 0x53.
- R11: reg_rdata holds the read value on the clock after a reg_rd edge. A read of 0x52 captures the current high byte for a later read of 0x53 and clears the count. Events in the same clock as that read are kept as the new count.
- R12: The event counter saturates at 0xFFFF.
- R13: After reset the pins read 2'b00 and los_out is 0. The event count is 0 and the mode register at address 0x00 reads 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_pos | input | 1 | Recovered positive rail |
| rx_neg | input | 1 | Recovered negative rail |
| fa_chk_vld | input | 1 | Alignment byte check result is valid this clock |
| fa1_bad | input | 1 | First alignment byte mismatched |
| fa2_bad | input | 1 | Second alignment byte mismatched |
| core_in_frame | input | 1 | Alignment core reports frame alignment held |
| ext_los | input | 1 | External loss-of-signal request |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, valid the clock after reg_rd |
| oof_out | output | 1 | Out-of-frame pin |
| lof_out | output | 1 | Loss-of-frame pin |
| los_out | output | 1 | Loss-of-signal pin |

## Verification
The assertions assume that a read strobe and a write strobe never fall in the same clock. They also assume that core_in_frame is a level held for whole clocks, and that the rails and ext_los change only between edges. The bench drives every input on the falling clock edge and issues one register access at a time. It holds the rails at ones between zero-run scenarios, so that a mode change never meets a partly built run. The out-of-frame interval is shortened by parameter so that the timed escalation can be counted edge by edge.

// File: rtl/e3ram_pkg.sv
// Package: shared constants and types for the E3 receive alarm monitor.
// Assumes an 8-bit register address space.
package e3ram_pkg;

    localparam logic [7:0] ADDR_MODE   = 8'h00;
    localparam logic [7:0] ADDR_ERR_LO = 8'h52;
    localparam logic [7:0] ADDR_ERR_HI = 8'h53;

    localparam int         MODE_INT_LOS_BIT = 5;
    localparam int         MODE_SHORT_BIT   = 1;
    localparam logic [7:0] MODE_RESET       = 8'h20;

    // Encoding is {lof, oof}; 2'b10 is deliberately unused.
    typedef enum logic [1:0] {
        FS_IN  = 2'b00,
        FS_OOF = 2'b01,
        FS_LOF = 2'b11
    } frm_state_e;

endpackage

// File: rtl/e3ram_los_det.sv
// Module: zero-run loss-of-signal detector.
// Counts consecutive clocks with both rails low and saturates at the longest
// threshold. Declares LOS from the external request or from any enabled
// run criterion. Assumes INT_RUN >= SHORT_RUN >= 1.
module e3ram_los_det #(
    parameter int INT_RUN   = 180,
    parameter int SHORT_RUN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pos,
    input  logic rx_neg,
    input  logic ext_los,
    input  logic int_en,
    input  logic short_en,
    output logic los
);

    localparam int                RUN_W     = $clog2(INT_RUN + 1);
    localparam logic [RUN_W-1:0]  RUN_MAX   = RUN_W'(INT_RUN);
    localparam logic [RUN_W-1:0]  SHORT_THR = RUN_W'(SHORT_RUN);

    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] run_nxt;
    logic             rail_one;
    logic             los_nxt;

    // Next run length: a one on either rail restarts the run, else saturating count.
    always_comb begin
        rail_one = rx_pos | rx_neg;
        if (rail_one)
            run_nxt = '0;
        else if (run_q == RUN_MAX)
            run_nxt = run_q;
        else
            run_nxt = run_q + 1'b1;
        los_nxt = ext_los
                | (int_en   && (run_nxt >= RUN_MAX))
                | (short_en && (run_nxt >= SHORT_THR));
    end

    // Register the run length and the LOS pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            los   <= 1'b0;
        end else begin
            run_q <= run_nxt;
            los   <= los_nxt;
        end
    end

    AST_EXT_FORCES_LOS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_los |=> los); // R7
    AST_ONE_CLEARS_LOS: assert property (@(posedge clk) disable iff (!rst_n)
        (rail_one && !ext_los) |=> !los); // R9
    AST_RUN_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rail_one && run_q == RUN_MAX) |=> run_q == RUN_MAX); // R9

endmodule

// File: rtl/e3ram_frm_state.sv
// Module: framing state tracker.
// Follows the alignment core's in-frame level. On loss it reports
// out-of-frame, and escalates to loss of frame after OOF_CLKS clocks without
// regain. Assumes OOF_CLKS >= 2.
module e3ram_frm_state
    import e3ram_pkg::*;
#(
    parameter int OOF_CLKS = 103104
) (
    input  logic clk,
    input  logic rst_n,
    input  logic core_in_frame,
    output logic oof,
    output logic lof
);

    localparam int               TMR_W    = $clog2(OOF_CLKS);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(OOF_CLKS - 1);

    frm_state_e       state_q;
    logic [TMR_W-1:0] tmr_q;

    // Advance the framing state and the out-of-frame timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IN;
            tmr_q   <= '0;
        end else begin
            case (state_q)
                FS_IN: begin
                    tmr_q <= '0;
                    if (!core_in_frame) state_q <= FS_OOF;
                end
                FS_OOF: begin
                    if (core_in_frame) begin
                        state_q <= FS_IN;
                        tmr_q   <= '0;
                    end else if (tmr_q == TMR_LAST) begin
                        state_q <= FS_LOF;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                FS_LOF: begin
                    tmr_q <= '0;
                    if (core_in_frame) state_q <= FS_IN;
                end
                default: begin
                    state_q <= FS_IN;
                    tmr_q   <= '0;
                end
            endcase
        end
    end

    // Drive the two pins straight from the state encoding.
    always_comb begin
        lof = state_q[1];
        oof = state_q[0];
    end

    AST_NO_INVALID_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        !(lof && !oof)); // R1
    AST_REGAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        core_in_frame |=> (!lof && !oof)); // R4
    AST_LOF_AFTER_OOF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lof) |-> $past(oof)); // R3
    AST_LOSS_TO_OOF: assert property (@(posedge clk) disable iff (!rst_n)
        (!core_in_frame && !oof) |=> (oof && !lof)); // R2

endmodule

// File: rtl/e3ram_err_cnt.sv
// Module: saturating framing-byte error event counter.
// Adds the number of active events each clock. A clear drops the old
// count but keeps the same clock's events. Assumes NUM_EV is small.
module e3ram_err_cnt #(
    parameter int CNT_W  = 16,
    parameter int NUM_EV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_EV-1:0] ev,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);

    localparam int               INC_W   = $clog2(NUM_EV + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [INC_W-1:0] inc;
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   sum;

    // Compute the saturating next count.
    always_comb begin
        inc  = INC_W'($countones(ev));
        base = clr ? '0 : cnt;
        sum  = {1'b0, base} + {{(CNT_W + 1 - INC_W){1'b0}}, inc};
    end

    // Hold the count register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else
            cnt <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end

    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt <= CNT_W'(NUM_EV)); // R11
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !clr) |=> cnt == CNT_MAX); // R12
    AST_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(clr) |-> cnt >= $past(cnt)); // R10

endmodule

// File: rtl/e3ram_regif.sv
// Module: byte register port.
// Holds the mode byte, returns read data one clock after a read, and
// captures the counter high byte when the low byte is read. Assumes reads
// and writes are not issued in the same clock.
module e3ram_regif
    import e3ram_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic [CNT_W-1:0] cnt,
    output logic [7:0]       reg_rdata,
    output logic             cnt_clr,
    output logic             int_en,
    output logic             short_en
);

    logic [7:0] mode_q;
    logic [7:0] hi_shadow_q;
    logic [7:0] rd_mux;

    // Decode the clear strobe and the mode bits.
    always_comb begin
        cnt_clr  = reg_rd && (reg_addr == ADDR_ERR_LO);
        int_en   = mode_q[MODE_INT_LOS_BIT];
        short_en = mode_q[MODE_SHORT_BIT];
        case (reg_addr)
            ADDR_MODE:   rd_mux = mode_q;
            ADDR_ERR_LO: rd_mux = cnt[7:0];
            ADDR_ERR_HI: rd_mux = hi_shadow_q;
            default:     rd_mux = 8'h00;
        endcase
    end

    // Mode write, high-byte capture and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= MODE_RESET;
            hi_shadow_q <= 8'h00;
            reg_rdata   <= 8'h00;
        end else begin
            if (reg_wr && reg_addr == ADDR_MODE) mode_q <= reg_wdata;
            if (cnt_clr) hi_shadow_q <= cnt[15:8];
            if (reg_rd) reg_rdata <= rd_mux;
        end
    end

    AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_wr)); // R11
    AST_HI_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_clr |=> $stable(hi_shadow_q)); // R11

endmodule

// File: rtl/e3_rx_alarm_mon.sv
// Module: top of the E3 receive alarm monitor.
// Connects the LOS detector, the framing state tracker, the error event
// counter and the register port. All inputs are synchronous to clk.
module e3_rx_alarm_mon #(
    parameter int OOF_CLKS  = 103104,
    parameter int INT_RUN   = 180,
    parameter int SHORT_RUN = 32,
    parameter int CNT_W     = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pos,
    input  logic       rx_neg,
    input  logic       fa_chk_vld,
    input  logic       fa1_bad,
    input  logic       fa2_bad,
    input  logic       core_in_frame,
    input  logic       ext_los,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       oof_out,
    output logic       lof_out,
    output logic       los_out
);

    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             int_en;
    logic             short_en;
    logic [1:0]       ev;

    // Qualify the alignment byte results with the check strobe.
    always_comb begin
        ev = {fa2_bad & fa_chk_vld, fa1_bad & fa_chk_vld};
    end

    e3ram_los_det #(.INT_RUN(INT_RUN), .SHORT_RUN(SHORT_RUN)) u_los (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_pos   (rx_pos),
        .rx_neg   (rx_neg),
        .ext_los  (ext_los),
        .int_en   (int_en),
        .short_en (short_en),
        .los      (los_out)
    );

    e3ram_frm_state #(.OOF_CLKS(OOF_CLKS)) u_frm (
        .clk           (clk),
        .rst_n         (rst_n),
        .core_in_frame (core_in_frame),
        .oof           (oof_out),
        .lof           (lof_out)
    );

    e3ram_err_cnt #(.CNT_W(CNT_W), .NUM_EV(2)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    e3ram_regif #(.CNT_W(CNT_W)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cnt       (cnt),
        .reg_rdata (reg_rdata),
        .cnt_clr   (cnt_clr),
        .int_en    (int_en),
        .short_en  (short_en)
    );

endmodule

// File: tb/tb_e3_rx_alarm_mon.sv
module tb_e3_rx_alarm_mon;

    localparam int OOF_N = 200;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       rx_pos, rx_neg, fa_chk_vld, fa1_bad, fa2_bad;
    logic       core_in_frame, ext_los, reg_wr, reg_rd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       oof_out, lof_out, los_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    bit  bad_code = 1'b0;

    always #2 clk = ~clk;

    e3_rx_alarm_mon #(.OOF_CLKS(OOF_N)) dut (
        .clk(clk), .rst_n(rst_n), .rx_pos(rx_pos), .rx_neg(rx_neg),
        .fa_chk_vld(fa_chk_vld), .fa1_bad(fa1_bad), .fa2_bad(fa2_bad),
        .core_in_frame(core_in_frame), .ext_los(ext_los),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .oof_out(oof_out), .lof_out(lof_out), .los_out(los_out)
    );

    always @(negedge clk) if (rst_n === 1'b1 && lof_out && !oof_out) bad_code = 1'b1;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        reg_rd = 1'b1; reg_addr = a;
        step();
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic pins(input logic [1:0] exp, input string req);
        check({lof_out, oof_out} == exp, req, {lof_out, oof_out}, exp);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0; rx_pos = 1'b1; rx_neg = 1'b0; fa_chk_vld = 1'b0;
        fa1_bad = 1'b0; fa2_bad = 1'b0; core_in_frame = 1'b1; ext_los = 1'b0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = 8'h00; reg_wdata = 8'h00;
        step(3);
        rst_n = 1'b1;
        step();
        pins(2'b00, "R13 pins after reset");
        check(los_out == 1'b0, "R13 los after reset", los_out, 0);
        reg_read(8'h00, d);
        check(d == 8'h20, "R13 mode reset value", d, 8'h20);
        reg_read(8'h52, d);
        check(d == 8'h00, "R13 count low after reset", d, 0);
    endtask

    task automatic t_frame();
        core_in_frame = 1'b0;
        step();
        pins(2'b01, "R2 loss gives OOF");
        step(OOF_N - 1);
        pins(2'b01, "R3 still OOF before interval ends");
        step();
        pins(2'b11, "R3 LOF after interval");
        core_in_frame = 1'b1;
        step();
        pins(2'b00, "R4 regain from LOF");
        core_in_frame = 1'b0;
        step(50);
        core_in_frame = 1'b1;
        step();
        pins(2'b00, "R4 regain from OOF");
        core_in_frame = 1'b0;
        step(OOF_N);
        pins(2'b01, "R4 timer restarted");
        step();
        pins(2'b11, "R3 LOF after restarted interval");
        core_in_frame = 1'b1;
        step();
    endtask

    task automatic t_los_int();
        rx_pos = 1'b0; rx_neg = 1'b0;
        step(179);
        check(los_out == 1'b0, "R5 179 zeros no LOS", los_out, 0);
        step();
        check(los_out == 1'b1, "R5 180 zeros LOS", los_out, 1);
        step(400);
        check(los_out == 1'b1, "R9 LOS held in long run", los_out, 1);
        rx_pos = 1'b1;
        step();
        check(los_out == 1'b0, "R9 one clears LOS", los_out, 0);
    endtask

    task automatic t_los_short();
        reg_write(8'h00, 8'h02);
        rx_pos = 1'b0; rx_neg = 1'b0;
        step(31);
        check(los_out == 1'b0, "R6 31 zeros no LOS", los_out, 0);
        step();
        check(los_out == 1'b1, "R6 32 zeros LOS", los_out, 1);
        rx_neg = 1'b1;
        step();
        check(los_out == 1'b0, "R9 negative rail one clears", los_out, 0);
        rx_neg = 1'b0; rx_pos = 1'b1;
    endtask

    task automatic t_los_off();
        reg_write(8'h00, 8'h00);
        rx_pos = 1'b0; rx_neg = 1'b0;
        step(400);
        check(los_out == 1'b0, "R8 detectors off no LOS", los_out, 0);
        rx_pos = 1'b1;
        step();
    endtask

    task automatic t_los_ext();
        ext_los = 1'b1;
        step();
        check(los_out == 1'b1, "R7 external LOS", los_out, 1);
        step(5);
        check(los_out == 1'b1, "R7 external LOS held over ones", los_out, 1);
        ext_los = 1'b0;
        step();
        check(los_out == 1'b0, "R9 clears after external drop", los_out, 0);
        reg_write(8'h00, 8'h20);
    endtask

    task automatic t_errcnt();
        logic [7:0] d;
        fa_chk_vld = 1'b1; fa1_bad = 1'b1; fa2_bad = 1'b1;
        step(150);
        fa_chk_vld = 1'b0;
        fa2_bad = 1'b0;
        step(3);
        fa1_bad = 1'b0;
        fa_chk_vld = 1'b1; fa1_bad = 1'b1;
        step();
        fa_chk_vld = 1'b0; fa1_bad = 1'b0;
        reg_read(8'h52, d);
        check(d == 8'h2D, "R10 low byte of 301", d, 8'h2D);
        fa_chk_vld = 1'b1; fa1_bad = 1'b1; fa2_bad = 1'b1;
        step(128);
        fa_chk_vld = 1'b0; fa1_bad = 1'b0; fa2_bad = 1'b0;
        reg_read(8'h53, d);
        check(d == 8'h01, "R11 high byte coherent", d, 8'h01);
        fa_chk_vld = 1'b1; fa2_bad = 1'b1;
        reg_read(8'h52, d);
        fa_chk_vld = 1'b0; fa2_bad = 1'b0;
        check(d == 8'h00, "R11 cleared then 256 low", d, 0);
        reg_read(8'h53, d);
        check(d == 8'h01, "R10 high byte of 256", d, 8'h01);
        reg_read(8'h52, d);
        check(d == 8'h01, "R11 same-clock event kept", d, 8'h01);
    endtask

    task automatic t_sat();
        logic [7:0] d;
        fa_chk_vld = 1'b1; fa1_bad = 1'b1; fa2_bad = 1'b1;
        step(33000);
        fa_chk_vld = 1'b0; fa1_bad = 1'b0; fa2_bad = 1'b0;
        reg_read(8'h52, d);
        check(d == 8'hFF, "R12 saturated low", d, 8'hFF);
        reg_read(8'h53, d);
        check(d == 8'hFF, "R12 saturated high", d, 8'hFF);
        reg_read(8'h52, d);
        check(d == 8'h00, "R11 cleared after saturation", d, 0);
    endtask

    initial begin
        t_reset();
        t_frame();
        t_los_int();
        t_los_short();
        t_los_off();
        t_los_ext();
        t_errcnt();
        t_sat();
        check(!bad_code, "R1 code 10 never seen", bad_code, 0);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule